// File: doc/BRIEF.md
# Segmented Transmit Bus Packer

This block sits between user packet logic and a wide transmit bus. Beats arrive one at a time on a 128-bit valid/ready stream. Each beat carries a channel tag. The final beat of a packet also carries an end flag, an error flag and a count of its valid bytes. The block places successive beats into consecutive 128-bit lanes of a four-lane, 512-bit output word. Each lane has its own enable, start, end, error, empty-byte count and channel fields.

Because every lane carries complete control information, one packet can end in a lane and the next packet can start in the lane after it, in the same output word. A short packet therefore costs one lane rather than a whole 512-bit word.

A word is handed to a single output holding register when its last lane fills. It is also handed over early when the stream pauses, so a partial word does not wait for more traffic. The downstream side applies backpressure through a ready signal. While the held word is blocked, the upstream ready is withdrawn.

Top module: `segpack_tx`

## Requirements
- R1: Lane i occupies `out_data[128*i+127:128*i]`, `out_chan[11*i+10:11*i]`, `out_mty[4*i+3:4*i]` and bit i of `out_ena`, `out_sop`, `out_eop` and `out_err`. The first byte of a lane is held in the lane's top eight bits.
- R2: Accepted beats fill lanes in arrival order, starting at lane 0 and rising. The enabled lanes of a word are contiguous from lane 0. A packet that spills past lane 3 resumes in lane 0 of the next word. `out_ena` is all zero whenever `out_valid` is 0.
- R3: A word moves to the output when its fourth lane fills. A partial word also moves to the output in the first cycle in which no beat is accepted, provided the holding register is free.
- R4: `out_sop` is 1 only on the first beat of a packet, and `out_eop` is 1 only on the beat carrying `in_last`. When a lane ends a packet, the next enabled lane of the same word starts a new packet.
- R5: On an end lane, `out_mty` equals 16 minus `in_bytes`, where `in_bytes` is the valid byte count 1 to 16 in binary. On a lane that is not an end lane, `out_mty` is 0.
- R6: On an end lane, the bytes past the valid region are driven as zero. The valid region is the leading 16 minus `out_mty` bytes, counted from the top.
- R7: `out_err` is 1 only on an end lane whose beat had `in_err` set. On such a lane, `out_mty[2:0]` is 000 and `out_mty[3]` is bit 3 of 16 minus `in_bytes`.
- R8: Each lane's channel equals the `in_chan` value of the beat placed there.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, the output word stays unchanged. No beat is lost or repeated.
- R10: After reset, `out_valid` is 0, `out_ena` is 0 and `in_ready` is 1. The first accepted beat is marked as a packet start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_data | input | 128 | Beat payload, first byte at the top |
| in_chan | input | 11 | Channel tag of the beat |
| in_last | input | 1 | Beat ends its packet |
| in_err | input | 1 | Packet is bad (used with in_last) |
| in_bytes | input | 5 | Valid bytes on the end beat, 1 to 16 |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the word |
| out_ena | output | 4 | Per-lane enable |
| out_sop | output | 4 | Per-lane packet start |
| out_eop | output | 4 | Per-lane packet end |
| out_err | output | 4 | Per-lane error on the end lane |
| out_mty | output | 16 | Per-lane empty-byte count, 4 bits per lane |
| out_chan | output | 44 | Per-lane channel, 11 bits per lane |
| out_data | output | 512 | Per-lane payload, 128 bits per lane |

## Verification
The assertions assume two things about the input. The byte count offered with an end beat is between 1 and 16. A packet's channel does not change between its start and end beats. One input check guards the count. The directed and random stimulus always draws lengths of at least one byte and derives each end-beat count from the packet length, so the count always stays in range. Each packet also uses a single channel drawn once for all of its beats.

// File: rtl/segpack_pkg.sv
`timescale 1ns/1ps
package segpack_pkg;
    localparam int SEG_W     = 128;
    localparam int SEG_BYTES = SEG_W / 8;
    localparam int CHAN_W    = 11;
    localparam int MTY_W     = $clog2(SEG_BYTES);
    localparam int CNT_W     = $clog2(SEG_BYTES) + 1;

    typedef struct packed {
        logic [SEG_W-1:0]  data;
        logic [CHAN_W-1:0] chan;
        logic              sop;
        logic              eop;
        logic              err;
        logic [MTY_W-1:0]  mty;
    } seg_t;

    // empty-byte field for a beat: zero unless it ends a packet
    function automatic logic [MTY_W-1:0] empty_of(input logic [CNT_W-1:0] nbytes,
                                                  input logic last,
                                                  input logic bad);
        logic [CNT_W-1:0] gap;
        gap = CNT_W'(SEG_BYTES) - nbytes;
        if (!last)
            return '0;
        if (bad)
            return {gap[MTY_W-1], {(MTY_W-1){1'b0}}};
        return gap[MTY_W-1:0];
    endfunction

    // clear the trailing bytes that the empty count marks as unused
    function automatic logic [SEG_W-1:0] clear_tail(input logic [SEG_W-1:0] d,
                                                    input logic [MTY_W-1:0] mty);
        logic [SEG_W-1:0] r;
        r = d;
        for (int b = 0; b < SEG_BYTES; b++) begin
            if (b >= SEG_BYTES - int'(mty))
                r[SEG_W-1-8*b -: 8] = 8'h00;
        end
        return r;
    endfunction
endpackage

// File: rtl/segpack_format.sv
`timescale 1ns/1ps
module segpack_format
    import segpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [SEG_W-1:0]  d_in,
    input  logic [CHAN_W-1:0] ch_in,
    input  logic              last_in,
    input  logic              bad_in,
    input  logic [CNT_W-1:0]  nbytes_in,
    output seg_t              beat
);
    logic mid_pkt;

    always_ff @(posedge clk) begin
        if (rst)
            mid_pkt <= 1'b0;
        else if (take)
            mid_pkt <= !last_in;
    end

    always_comb begin
        beat.sop  = !mid_pkt;
        beat.eop  = last_in;
        beat.err  = last_in && bad_in;
        beat.chan = ch_in;
        beat.mty  = empty_of(nbytes_in, last_in, bad_in);
        beat.data = last_in ? clear_tail(d_in, beat.mty) : d_in;
    end
endmodule

// File: rtl/segpack_fill.sv
`timescale 1ns/1ps
module segpack_fill
    import segpack_pkg::*;
#(
    parameter int NSEG = 4
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  seg_t            beat,
    input  logic            hold_free,
    output logic            push,
    output seg_t            word [NSEG],
    output logic [NSEG-1:0] word_ena
);
    localparam int FILL_W = $clog2(NSEG) + 1;

    logic [FILL_W-1:0] fill;
    logic [FILL_W-1:0] fill_next;
    seg_t              slot [NSEG];

    assign fill_next = fill + FILL_W'(take);
    assign push = (take && fill == FILL_W'(NSEG - 1)) ||
                  (!take && fill != '0 && hold_free);

    always_ff @(posedge clk) begin
        if (rst)
            fill <= '0;
        else if (push)
            fill <= '0;
        else if (take)
            fill <= fill_next;
    end

    for (genvar i = 0; i < NSEG; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (take && fill == FILL_W'(i))
                slot[i] <= beat;
        end

        always_comb begin
            word[i]     = (take && fill == FILL_W'(i)) ? beat : slot[i];
            word_ena[i] = FILL_W'(i) < fill_next;
        end
    end
endmodule

// File: rtl/segpack_hold.sv
`timescale 1ns/1ps
module segpack_hold
    import segpack_pkg::*;
#(
    parameter int NSEG = 4
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  seg_t            word [NSEG],
    input  logic [NSEG-1:0] word_ena,
    input  logic            dn_ready,
    output logic            hold_free,
    output logic            held_valid,
    output seg_t            held [NSEG],
    output logic [NSEG-1:0] held_ena
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_valid <= 1'b0;
            held_ena   <= '0;
        end else if (push) begin
            held_valid <= 1'b1;
            held_ena   <= word_ena;
        end else if (dn_ready) begin
            held_valid <= 1'b0;
        end
    end

    for (genvar i = 0; i < NSEG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (push)
                held[i] <= word[i];
        end
    end

    assign hold_free = !held_valid || dn_ready;
endmodule

// File: rtl/segpack_tx.sv
`timescale 1ns/1ps
module segpack_tx
    import segpack_pkg::*;
#(
    parameter int NSEG = 4
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [SEG_W-1:0]        in_data,
    input  logic [CHAN_W-1:0]       in_chan,
    input  logic                    in_last,
    input  logic                    in_err,
    input  logic [CNT_W-1:0]        in_bytes,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [NSEG-1:0]         out_ena,
    output logic [NSEG-1:0]         out_sop,
    output logic [NSEG-1:0]         out_eop,
    output logic [NSEG-1:0]         out_err,
    output logic [NSEG*MTY_W-1:0]   out_mty,
    output logic [NSEG*CHAN_W-1:0]  out_chan,
    output logic [NSEG*SEG_W-1:0]   out_data
);
    logic            take;
    logic            hold_free;
    logic            push;
    seg_t            beat;
    seg_t            word [NSEG];
    seg_t            held [NSEG];
    logic [NSEG-1:0] word_ena;
    logic [NSEG-1:0] held_ena;

    assign in_ready = hold_free;
    assign take     = in_valid && in_ready;

    segpack_format u_format (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .d_in      (in_data),
        .ch_in     (in_chan),
        .last_in   (in_last),
        .bad_in    (in_err),
        .nbytes_in (in_bytes),
        .beat      (beat)
    );

    segpack_fill #(.NSEG(NSEG)) u_fill (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .beat      (beat),
        .hold_free (hold_free),
        .push      (push),
        .word      (word),
        .word_ena  (word_ena)
    );

    segpack_hold #(.NSEG(NSEG)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .word       (word),
        .word_ena   (word_ena),
        .dn_ready   (out_ready),
        .hold_free  (hold_free),
        .held_valid (out_valid),
        .held       (held),
        .held_ena   (held_ena)
    );

    for (genvar i = 0; i < NSEG; i++) begin : g_lane
        assign out_ena[i]                     = out_valid && held_ena[i];
        assign out_sop[i]                     = held[i].sop;
        assign out_eop[i]                     = held[i].eop;
        assign out_err[i]                     = held[i].err;
        assign out_mty[i*MTY_W +: MTY_W]      = held[i].mty;
        assign out_chan[i*CHAN_W +: CHAN_W]   = held[i].chan;
        assign out_data[i*SEG_W +: SEG_W]     = held[i].data;
    end
endmodule

// File: rtl/segpack_tx_chk.sv
`timescale 1ns/1ps
module segpack_tx_chk
    import segpack_pkg::*;
#(
    parameter int NSEG = 4
)(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    in_last,
    input logic [CNT_W-1:0]        in_bytes,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [NSEG-1:0]         out_ena,
    input logic [NSEG-1:0]         out_sop,
    input logic [NSEG-1:0]         out_eop,
    input logic [NSEG-1:0]         out_err,
    input logic [NSEG*MTY_W-1:0]   out_mty,
    input logic [NSEG*SEG_W-1:0]   out_data
);
    // input check: end-beat byte count stays in 1..16
    in_count_range_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_last |-> (in_bytes != '0 && in_bytes <= CNT_W'(SEG_BYTES)));

    // R2
    lanes_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_ena == '0);

    // R2
    lanes_contig_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_ena[0] && ((out_ena & NSEG'(out_ena + 1'b1)) == '0));

    // R9
    ready_block_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_ena) && $stable(out_data)
                                   && $stable(out_mty) && $stable(out_sop) && $stable(out_eop));

    for (genvar i = 0; i < NSEG; i++) begin : g_lane
        // R7
        err_mty_chk: assert property (@(posedge clk) disable iff (rst)
            out_ena[i] && out_err[i] |-> out_eop[i] && out_mty[i*MTY_W +: 3] == 3'b000);

        // R5
        mid_mty_chk: assert property (@(posedge clk) disable iff (rst)
            out_ena[i] && !out_eop[i] |-> out_mty[i*MTY_W +: MTY_W] == '0 && !out_err[i]);

        if (i > 0) begin : g_next
            // R4
            sop_after_eop_chk: assert property (@(posedge clk) disable iff (rst)
                out_ena[i] && out_eop[i-1] |-> out_sop[i]);
        end
    end
endmodule

bind segpack_tx segpack_tx_chk #(.NSEG(NSEG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .in_bytes  (in_bytes),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_ena   (out_ena),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_err   (out_err),
    .out_mty   (out_mty),
    .out_data  (out_data)
);

// File: tb/segpack_tx_test.sv
`timescale 1ns/1ps
module segpack_tx_test;
    import segpack_pkg::*;
    localparam int NSEG = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [127:0] in_data = '0;
    logic [10:0] in_chan = '0;
    logic in_last = 1'b0;
    logic in_err = 1'b0;
    logic [4:0] in_bytes = 5'd16;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [3:0] out_ena, out_sop, out_eop, out_err;
    logic [15:0] out_mty;
    logic [43:0] out_chan;
    logic [511:0] out_data;

    int checks = 0;
    int errors = 0;
    int words = 0;
    bit bp_mode = 1'b0;
    bit done = 1'b0;
    logic [3:0] last_ena, last_sop, last_eop;
    seg_t exp_q [$];

    always #2 clk = ~clk;

    segpack_tx #(.NSEG(NSEG)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_chan(in_chan), .in_last(in_last), .in_err(in_err),
        .in_bytes(in_bytes), .out_valid(out_valid), .out_ready(out_ready),
        .out_ena(out_ena), .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
        .out_mty(out_mty), .out_chan(out_chan), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected lane contents, built from the requirement text
    function automatic seg_t model(input logic [127:0] d, input logic [10:0] ch,
                                   input bit first, input bit last, input bit bad,
                                   input int nbytes);
        seg_t s;
        logic [4:0] gap;
        gap = 5'(16 - nbytes);
        s.chan = ch;
        s.sop  = first;
        s.eop  = last;
        s.err  = last && bad;
        s.mty  = !last ? 4'd0 : (bad ? {gap[3], 3'b000} : gap[3:0]);
        s.data = d;
        if (last)
            for (int k = 0; k < 16; k++)
                if (k >= 16 - int'(s.mty)) s.data[127-8*k -: 8] = 8'h00;
        return s;
    endfunction

    // downstream ready pattern
    always @(posedge clk) begin
        #1;
        out_ready <= bp_mode ? ($urandom % 3 != 0) : 1'b1;
    end

    // scoreboard on accepted output words
    always @(negedge clk) begin
        if (!rst && out_valid && !out_ready)
            check(in_ready == 1'b0, "R9", "in_ready while blocked", 128'(in_ready), 128'd0);
        if (!rst && out_valid && out_ready) begin
            words++;
            last_ena = out_ena;
            last_sop = out_sop;
            last_eop = out_eop;
            for (int i = 0; i < NSEG; i++) begin
                if (i > 0 && out_ena[i])
                    check(out_ena[i-1], "R2", "lane gap", 128'(out_ena), 128'd0);
                if (out_ena[i]) begin
                    seg_t e;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9", "extra lane", 128'(i), 128'd0);
                    end else begin
                        e = exp_q.pop_front();
                        check(out_data[i*128 +: 128] == e.data, "R6", "lane data",
                              out_data[i*128 +: 128], e.data);
                        check(out_chan[i*11 +: 11] == e.chan, "R8", "lane channel",
                              128'(out_chan[i*11 +: 11]), 128'(e.chan));
                        check({out_sop[i], out_eop[i]} == {e.sop, e.eop}, "R4", "start/end",
                              128'({out_sop[i], out_eop[i]}), 128'({e.sop, e.eop}));
                        check({out_err[i], out_mty[i*4 +: 4]} == {e.err, e.mty}, "R5",
                              "error/empty (R7)", 128'({out_err[i], out_mty[i*4 +: 4]}),
                              128'({e.err, e.mty}));
                    end
                end
            end
        end
    end

    task automatic send_beat(input logic [127:0] d, input logic [10:0] ch,
                             input bit last, input bit bad, input int nbytes);
        bit acc;
        in_valid = 1'b1;
        in_data  = d;
        in_chan  = ch;
        in_last  = last;
        in_err   = bad;
        in_bytes = 5'(nbytes);
        forever begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
            if (acc) break;
        end
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_err   = 1'b0;
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send_pkt(input int len, input logic [10:0] ch, input bit bad);
        int nb;
        nb = (len + 15) / 16;
        for (int b = 0; b < nb; b++) begin
            logic [127:0] d;
            bit last;
            int cnt;
            d = {$urandom, $urandom, $urandom, $urandom};
            last = (b == nb - 1);
            cnt = last ? len - 16 * b : 16;
            exp_q.push_back(model(d, ch, b == 0, last, bad, cnt));
            send_beat(d, ch, last, bad, last ? cnt : 16);
        end
    endtask

    task automatic drain(input string req);
        int n;
        idle(1);
        n = 0;
        while (exp_q.size() != 0 && n < 2000) begin
            idle(1);
            n++;
        end
        check(exp_q.size() == 0, req, "lanes still pending", 128'(exp_q.size()), 128'd0);
        idle(2);
    endtask

    task automatic t_reset;
        check(out_valid == 1'b0, "R10", "out_valid after reset", 128'(out_valid), 128'd0);
        check(out_ena == 4'd0, "R10", "out_ena after reset", 128'(out_ena), 128'd0);
        check(in_ready == 1'b1, "R10", "in_ready after reset", 128'(in_ready), 128'd1);
    endtask

    task automatic t_one_byte;
        send_pkt(1, 11'd5, 1'b0);
        drain("R5");
        check(last_ena == 4'b0001, "R3", "flushed partial word", 128'(last_ena), 128'b0001);
    endtask

    task automatic t_16_17;
        send_pkt(16, 11'd100, 1'b0);
        send_pkt(17, 11'd2047, 1'b0);
        drain("R6");
        check(last_ena == 4'b0111, "R1", "three lanes used", 128'(last_ena), 128'b0111);
    endtask

    task automatic t_packed;
        int w0;
        w0 = words;
        send_pkt(3, 11'd1, 1'b0);
        send_pkt(16, 11'd2, 1'b0);
        send_pkt(9, 11'd3, 1'b0);
        send_pkt(14, 11'd4, 1'b0);
        drain("R4");
        check(words - w0 == 1, "R3", "one word for four beats", 128'(words - w0), 128'd1);
        check(last_sop == 4'b1111 && last_eop == 4'b1111, "R4", "four packets in one word",
              128'({last_sop, last_eop}), 128'hff);
    endtask

    task automatic t_span;
        send_pkt(80, 11'd77, 1'b0);
        drain("R2");
        check(last_ena == 4'b0001 && last_sop == 4'b0000, "R2", "continuation in lane 0",
              128'({last_ena, last_sop}), 128'h10);
    endtask

    task automatic t_error;
        send_pkt(5, 11'd9, 1'b1);
        send_pkt(8, 11'd9, 1'b1);
        send_pkt(32, 11'd9, 1'b1);
        send_pkt(20, 11'd9, 1'b0);
        drain("R7");
    endtask

    task automatic t_backpressure;
        bp_mode = 1'b1;
        for (int p = 0; p < 40; p++)
            send_pkt(1 + $urandom % 70, 11'($urandom), 1'b0);
        drain("R9");
        bp_mode = 1'b0;
        idle(2);
    endtask

    task automatic t_random;
        for (int p = 0; p < 80; p++) begin
            send_pkt(1 + $urandom % 70, 11'($urandom), ($urandom % 5) == 0);
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end
        drain("R8");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        @(posedge clk);
        #1;
        t_one_byte();
        t_16_17();
        t_packed();
        t_span();
        t_error();
        t_backpressure();
        t_random();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule